// File: doc/BRIEF.md
# Decoupled Sector Cache Tag Directory

This block is the on-chip tag directory for a large, page-grained cache that sits off the chip. Every tag names one whole memory page, and the page is split into sub-blocks the size of a second-level cache line, each with its own valid state. The tags of a set are kept set-associatively. The data side is direct-mapped: the address alone picks the data frame of a page, and each set owns exactly one frame. Each sub-block slot of a frame therefore records which tag way currently owns it. This lets two pages that collide on the same frame both keep their tags, while they compete only for individual sub-block slots.

A lookup is issued on a first-level miss, in parallel with the second-level access. The verdict comes back one cycle later as one of three classes. A full hit means the data is present. A page hit with a missing sub-block means only the line has to be fetched. A full miss means a page tag must also be installed. The verdict comes with the matching way and the frame index.

A fill request installs the page tag if it is absent, choosing the victim way round-robin per set. It then marks the addressed sub-block valid and owned by the page's way.

Top module: `sdt_dir`

## Requirements
- R1: After reset no tag is valid, so any lookup returns a full miss.
- R2: A lookup request yields, on the next cycle, `lkp_vld_o` high with exactly one of hit, partial or miss asserted. A cycle without a request yields `lkp_vld_o` low on the next cycle. On a miss, `lkp_way_o` reads 0.
- R3: The address splits into four fields, from the most significant bit down: tag, set index, sub-block index, and line offset. With the defaults these are bits 31..13, 12..9, 8..6 and 5..0, and the line offset is ignored. A lookup is a full hit when a valid tag way of the set matches, the sub-block is valid, and its owner is that way. It reports that way, and the set index as `lkp_frame_o`.
- R4: When a tag matches but the sub-block is invalid, or is owned by another way, the lookup reports partial with the matching way.
- R5: Filling a sub-block hands its owner pointer to the filling page's way. A lookup of the other page on that sub-block then reports partial.
- R6: Two pages that map to the same set can hold tags in different ways at once, and each hits on the sub-blocks it owns.
- R7: A fill whose page has no matching tag installs the tag in the set's round-robin way. That pointer starts at way 0 after reset and advances by one, modulo the way count, on each such installation.
- R8: When a way is overwritten with a new page, every sub-block of the frame that this way owned becomes invalid. The evicted page then misses, and the new page reads partial on those sub-blocks.
- R9: A fill for a page whose tag is already present installs no tag and leaves the round-robin pointer unchanged.
- R10: When a lookup and a fill occur in the same cycle, the lookup result reflects the state before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lkp_req_i | input | 1 | Lookup request (first-level miss) |
| lkp_addr_i | input | ADDR_W | Physical address to look up |
| fill_req_i | input | 1 | Fill request for one sub-block |
| fill_addr_i | input | ADDR_W | Physical address of the filled sub-block |
| lkp_vld_o | output | 1 | Lookup result valid |
| lkp_hit_o | output | 1 | Full hit |
| lkp_part_o | output | 1 | Page tag hit, sub-block miss |
| lkp_miss_o | output | 1 | No page tag matched |
| lkp_way_o | output | WAY_W | Matching tag way (0 on miss) |
| lkp_frame_o | output | SET_W | Direct-mapped data frame index |

## Verification
The assertions assume that fills are the only way tags enter the directory. Under that assumption a set can never hold the same page in two ways. They also assume that the address fields are decoded as described, with no outside source of tag writes. The stimulus keeps to this by driving only the two request ports. It confines random tags and sets to a handful of values, so that conflicts, way evictions and sub-block ownership changes happen often. Fills and lookups are mixed freely, including in the same cycle.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  typedef enum logic [1:0] {
    LK_MISS = 2'd0,
    LK_PART = 2'd1,
    LK_HIT  = 2'd2
  } lk_class_e;
endpackage

// File: rtl/sdt_tag_store.sv
module sdt_tag_store #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 2,
  parameter int TAG_W    = 19,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SET_W-1:0]    lk_set_i,
  input  logic [TAG_W-1:0]    lk_tag_i,
  output logic [NUM_WAYS-1:0] lk_match_o,
  input  logic                fl_en_i,
  input  logic [SET_W-1:0]    fl_set_i,
  input  logic [TAG_W-1:0]    fl_tag_i,
  output logic [WAY_W-1:0]    fl_way_o,
  output logic                fl_alloc_o
);
  logic [TAG_W-1:0]    tag_q  [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] tvld_q [NUM_SETS];
  logic [WAY_W-1:0]    rr_q   [NUM_SETS];
  logic [NUM_WAYS-1:0] fl_match;
  logic [WAY_W-1:0]    fl_hit_way;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign lk_match_o[w] = tvld_q[lk_set_i][w] && (tag_q[lk_set_i][w] == lk_tag_i);
    assign fl_match[w]   = tvld_q[fl_set_i][w] && (tag_q[fl_set_i][w] == fl_tag_i);
  end

  always_comb begin
    fl_hit_way = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (fl_match[w]) fl_hit_way = WAY_W'(w);
  end

  assign fl_alloc_o = fl_en_i && !(|fl_match);
  assign fl_way_o   = fl_alloc_o ? rr_q[fl_set_i] : fl_hit_way;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        tvld_q[s] <= '0;
        rr_q[s]   <= '0;
      end
    end else if (fl_alloc_o) begin
      tvld_q[fl_set_i][rr_q[fl_set_i]] <= 1'b1;
      rr_q[fl_set_i] <= (rr_q[fl_set_i] == WAY_W'(NUM_WAYS - 1)) ? '0 : rr_q[fl_set_i] + 1'b1;
    end
  end

  // tag bits are qualified by tvld_q, no reset needed
  always_ff @(posedge clk_i) begin
    if (fl_alloc_o) tag_q[fl_set_i][rr_q[fl_set_i]] <= fl_tag_i;
  end

  AST_MATCH_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match_o)); // R9

  AST_ALLOC_INSTALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_alloc_o |=> tvld_q[$past(fl_set_i)][$past(fl_way_o)]
                   && (tag_q[$past(fl_set_i)][$past(fl_way_o)] == $past(fl_tag_i))); // R7

  if (NUM_WAYS > 1) begin : g_rr_chk
    AST_RR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fl_alloc_o |=> rr_q[$past(fl_set_i)] != $past(rr_q[fl_set_i])); // R7
  end

  AST_NO_ALLOC_KEEPS_RR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_en_i && !fl_alloc_o) |=> rr_q[$past(fl_set_i)] == $past(rr_q[fl_set_i])); // R9
endmodule

// File: rtl/sdt_frame_store.sv
module sdt_frame_store #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 2,
  parameter int NUM_SUBS = 8,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int SUB_W   = $clog2(NUM_SUBS),
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [SUB_W-1:0] lk_sub_i,
  output logic             lk_vld_o,
  output logic [WAY_W-1:0] lk_owner_o,
  input  logic             fl_en_i,
  input  logic             fl_alloc_i,
  input  logic [SET_W-1:0] fl_set_i,
  input  logic [SUB_W-1:0] fl_sub_i,
  input  logic [WAY_W-1:0] fl_way_i
);
  logic [NUM_SUBS-1:0] svld_q  [NUM_SETS];
  logic [WAY_W-1:0]    owner_q [NUM_SETS][NUM_SUBS];
  logic [NUM_SUBS-1:0] victim_mask;

  assign lk_vld_o   = svld_q[lk_set_i][lk_sub_i];
  assign lk_owner_o = owner_q[lk_set_i][lk_sub_i];

  // slots owned by a way being overwritten lose validity
  for (genvar s = 0; s < NUM_SUBS; s++) begin : g_vic
    assign victim_mask[s] = fl_alloc_i && (owner_q[fl_set_i][s] == fl_way_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) svld_q[s] <= '0;
    end else if (fl_en_i) begin
      svld_q[fl_set_i] <= (svld_q[fl_set_i] & ~victim_mask) | (NUM_SUBS'(1) << fl_sub_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (fl_en_i) owner_q[fl_set_i][fl_sub_i] <= fl_way_i;
  end

  AST_FILL_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_en_i |=> svld_q[$past(fl_set_i)][$past(fl_sub_i)]
                && (owner_q[$past(fl_set_i)][$past(fl_sub_i)] == $past(fl_way_i))); // R5

  AST_NO_FILL_NO_NEW_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_en_i |=> svld_q[$past(lk_set_i)] == $past(svld_q[lk_set_i])); // R8
endmodule

// File: rtl/sdt_dir.sv
module sdt_dir #(
  parameter int ADDR_W   = 32,
  parameter int LINE_W   = 6,
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 2,
  parameter int NUM_SUBS = 8,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int SUB_W   = $clog2(NUM_SUBS),
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int TAG_W   = ADDR_W - LINE_W - SUB_W - SET_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_req_i,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  input  logic              fill_req_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  output logic              lkp_vld_o,
  output logic              lkp_hit_o,
  output logic              lkp_part_o,
  output logic              lkp_miss_o,
  output logic [WAY_W-1:0]  lkp_way_o,
  output logic [SET_W-1:0]  lkp_frame_o
);
  import sdt_pkg::*;

  localparam int SUB_LO = LINE_W;
  localparam int SET_LO = LINE_W + SUB_W;
  localparam int TAG_LO = SET_LO + SET_W;

  logic [SUB_W-1:0] lk_sub, fl_sub;
  logic [SET_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;

  assign lk_sub = lkp_addr_i[SUB_LO +: SUB_W];
  assign lk_set = lkp_addr_i[SET_LO +: SET_W];
  assign lk_tag = lkp_addr_i[TAG_LO +: TAG_W];
  assign fl_sub = fill_addr_i[SUB_LO +: SUB_W];
  assign fl_set = fill_addr_i[SET_LO +: SET_W];
  assign fl_tag = fill_addr_i[TAG_LO +: TAG_W];

  logic [NUM_WAYS-1:0] lk_match;
  logic [WAY_W-1:0]    fl_way;
  logic                fl_alloc;
  logic                lk_sub_vld;
  logic [WAY_W-1:0]    lk_owner;

  sdt_tag_store #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)
  ) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_set_i   (lk_set),
    .lk_tag_i   (lk_tag),
    .lk_match_o (lk_match),
    .fl_en_i    (fill_req_i),
    .fl_set_i   (fl_set),
    .fl_tag_i   (fl_tag),
    .fl_way_o   (fl_way),
    .fl_alloc_o (fl_alloc)
  );

  sdt_frame_store #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .NUM_SUBS(NUM_SUBS)
  ) u_frames (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_set_i   (lk_set),
    .lk_sub_i   (lk_sub),
    .lk_vld_o   (lk_sub_vld),
    .lk_owner_o (lk_owner),
    .fl_en_i    (fill_req_i),
    .fl_alloc_i (fl_alloc),
    .fl_set_i   (fl_set),
    .fl_sub_i   (fl_sub),
    .fl_way_i   (fl_way)
  );

  logic [WAY_W-1:0] lk_way;
  lk_class_e        lk_cls;

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (lk_match[w]) lk_way = WAY_W'(w);
  end

  always_comb begin
    if (!(|lk_match))                        lk_cls = LK_MISS;
    else if (lk_sub_vld && lk_owner == lk_way) lk_cls = LK_HIT;
    else                                     lk_cls = LK_PART;
  end

  logic             vld_q;
  lk_class_e        cls_q;
  logic [WAY_W-1:0] way_q;
  logic [SET_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      cls_q   <= LK_MISS;
      way_q   <= '0;
      frame_q <= '0;
    end else begin
      vld_q <= lkp_req_i;
      if (lkp_req_i) begin
        cls_q   <= lk_cls;
        way_q   <= lk_way;
        frame_q <= lk_set;
      end
    end
  end

  assign lkp_vld_o   = vld_q;
  assign lkp_hit_o   = vld_q && (cls_q == LK_HIT);
  assign lkp_part_o  = vld_q && (cls_q == LK_PART);
  assign lkp_miss_o  = vld_q && (cls_q == LK_MISS);
  assign lkp_way_o   = way_q;
  assign lkp_frame_o = frame_q;

  AST_ONE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_vld_o |-> $countones({lkp_hit_o, lkp_part_o, lkp_miss_o}) == 1); // R2

  AST_REQ_GIVES_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_i |=> lkp_vld_o); // R2

  AST_IDLE_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_req_i |=> !lkp_vld_o); // R2

  AST_FRAME_FROM_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_i |=> lkp_frame_o == $past(lk_set)); // R3

  AST_MISS_WAY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_miss_o |-> lkp_way_o == '0); // R2
endmodule

// File: tb/tb_sdt_dir.sv
module tb_sdt_dir;
  localparam int SETS = 16, WAYS = 2, SUBS = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        lkp_req_i, fill_req_i;
  logic [31:0] lkp_addr_i, fill_addr_i;
  logic        lkp_vld_o, lkp_hit_o, lkp_part_o, lkp_miss_o;
  logic [0:0]  lkp_way_o;
  logic [3:0]  lkp_frame_o;

  always #5 clk_i = ~clk_i;

  sdt_dir dut (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  int  m_tag [SETS][WAYS];
  bit  m_tv  [SETS][WAYS];
  int  m_rr  [SETS];
  bit  m_sv  [SETS][SUBS];
  int  m_own [SETS][SUBS];

  function automatic logic [31:0] mk(int tag, int set, int sub);
    return {19'(tag), 4'(set), 3'(sub), 6'($urandom_range(0, 63))};
  endfunction

  function automatic int find(int set, int tag);
    for (int w = 0; w < WAYS; w++)
      if (m_tv[set][w] && m_tag[set][w] == tag) return w;
    return -1;
  endfunction

  function automatic void m_reset();
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) m_tv[s][w] = 0;
      for (int b = 0; b < SUBS; b++) begin m_sv[s][b] = 0; m_own[s][b] = 0; end
    end
  endfunction

  function automatic void m_fill(logic [31:0] a);
    int set = int'(a[12:9]), sub = int'(a[8:6]), tag = int'(a[31:13]);
    int w = find(set, tag);
    if (w < 0) begin
      w = m_rr[set];
      m_tag[set][w] = tag; m_tv[set][w] = 1;
      for (int b = 0; b < SUBS; b++) if (m_own[set][b] == w) m_sv[set][b] = 0;
      m_rr[set] = (m_rr[set] + 1) % WAYS;
    end
    m_sv[set][sub] = 1; m_own[set][sub] = w;
  endfunction

  // expected class: 0 miss, 1 part, 2 hit
  function automatic int m_cls(logic [31:0] a, output int way);
    int set = int'(a[12:9]), sub = int'(a[8:6]), tag = int'(a[31:13]);
    int w = find(set, tag);
    way = (w < 0) ? 0 : w;
    if (w < 0) return 0;
    if (m_sv[set][sub] && m_own[set][sub] == w) return 2;
    return 1;
  endfunction

  task automatic step(bit lk, logic [31:0] la, bit fl, logic [31:0] fa, string lbl);
    int ecls, eway;
    ecls = 0; eway = 0;
    lkp_req_i = lk; lkp_addr_i = la; fill_req_i = fl; fill_addr_i = fa;
    if (lk) ecls = m_cls(la, eway);
    if (fl) m_fill(fa);
    @(posedge clk_i); @(negedge clk_i);
    lkp_req_i = 0; fill_req_i = 0;
    n_tests++;
    if (!lk) begin
      if (lkp_vld_o !== 1'b0) begin
        n_fail++;
        $display("FAIL %s: vld=%b expected 0", lbl, lkp_vld_o);
      end
    end else if (lkp_vld_o !== 1'b1 || lkp_hit_o !== (ecls == 2) || lkp_part_o !== (ecls == 1)
                 || lkp_miss_o !== (ecls == 0) || int'(lkp_way_o) != eway
                 || lkp_frame_o !== la[12:9]) begin
      n_fail++;
      $display("FAIL %s: vld/hit/part/miss=%b%b%b%b way=%0d frame=%0d expected cls=%0d way=%0d frame=%0d",
               lbl, lkp_vld_o, lkp_hit_o, lkp_part_o, lkp_miss_o, lkp_way_o, lkp_frame_o,
               ecls, eway, la[12:9]);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a0, a1, b0, b1, b2, c0, c2, d3;
    void'($urandom(32'd4242));
    m_reset();
    rst_ni = 0; lkp_req_i = 0; fill_req_i = 0; lkp_addr_i = '0; fill_addr_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    a0 = mk(1, 0, 0); a1 = mk(1, 0, 1);
    b0 = mk(2, 0, 0); b1 = mk(2, 0, 1); b2 = mk(2, 0, 2);
    c0 = mk(3, 0, 0); c2 = mk(3, 0, 2); d3 = mk(4, 0, 3);

    step(1, a0, 0, '0, "R1 reset miss");
    step(0, '0, 0, '0, "R2 idle no result");
    step(1, a0, 1, a0, "R10 same-cycle sees old state");
    step(1, a0, 0, '0, "R3 full hit way0");
    step(1, a1, 0, '0, "R4 partial");
    step(0, '0, 1, b1, "R7 fill alloc way1");
    step(1, b1, 0, '0, "R6 second page hits");
    step(1, a0, 0, '0, "R6 first page still hits");
    step(0, '0, 1, b0, "R5 steal sub0");
    step(1, a0, 0, '0, "R5 stolen sub partial");
    step(1, b0, 0, '0, "R5 new owner hit");
    step(0, '0, 1, a0, "R9 refill existing page");
    step(0, '0, 1, c2, "R7 victim way0");
    step(1, a0, 0, '0, "R8 evicted page miss");
    step(1, c0, 0, '0, "R8 victim subs invalid");
    step(1, b1, 0, '0, "R8 other way kept");
    step(1, c2, 0, '0, "R7 new page hit way0");
    step(0, '0, 1, d3, "R7 next victim way1");
    step(1, d3, 0, '0, "R7 rr advanced");
    step(1, b2, 0, '0, "R8 evicted second page miss");
    step(1, mk(9, 5, 4), 0, '0, "R3 other set miss");

    for (int i = 0; i < 3000; i++) begin
      bit lk = $urandom_range(0, 3) != 0;
      bit fl = $urandom_range(0, 2) == 0;
      logic [31:0] la = mk($urandom_range(0, 3), $urandom_range(0, 2), $urandom_range(0, SUBS - 1));
      logic [31:0] fa = mk($urandom_range(0, 3), $urandom_range(0, 2), $urandom_range(0, SUBS - 1));
      step(lk, la, fl, fa, "R3/R4/R5/R7/R8 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule